// File: doc/BRIEF.md
# Multicycle Phase-Error Detector

This block measures the phase error between a digital PLL's reference clock and its feedback clock. Both clocks reach it as one-cycle edge strobes that are already in the system clock domain. It is built for references up to 77.76 MHz. On every reference edge it emits a signed phase-error word with two fields. The upper field is a cycle-slip count. The lower field is a fine early/late fraction measured in system clock ticks.

In combined mode the slip count keeps the accumulated difference between reference and feedback edges, up to 8191 unit intervals either way. Large input jitter therefore does not wrap the error at one cycle, and pull-in is faster. In plain mode the same counter behaves as a classic three-state phase/frequency detector and is held to plus or minus one cycle. The loop controller chooses the mode. A low-rate flag, set for references of 8 kHz or slower, forces plain mode whatever the mode input says. A synchronous clear empties the slip count when the loop goes back into acquisition.

Top module: `phase_err_mcpd`

## Requirements
- R1: During and after reset, err_out is 0 and err_valid is 0 until the first reference edge has been sampled.
- R2: err_valid goes high for exactly one cycle, in the cycle after each sampled ref_edge, and never at any other time. err_out changes only in a cycle where err_valid is high.
- R3: In combined mode (mode_multi=1, low_rate=0) the slip count rises by one on a cycle with ref_edge alone, falls by one on a cycle with fb_edge alone, and stays the same when both strobes or neither are present. Feedback edges between samples are counted too. The sampled count is the value after that cycle's update, and it appears in err_out[OUT_W-1:FRAC_W] as a two's-complement number.
- R4: In combined mode the slip count saturates at +8191 and at -8191 (MAX_SLIP). Extra edges in the saturated direction are ignored.
- R5: In plain mode (mode_multi=0) the slip count is limited to -1..+1. A larger stored count is clamped into that range on the first cycle of plain mode.
- R6: low_rate=1 forces plain mode (R5) even when mode_multi=1.
- R7: The fine field err_out[FRAC_W-1:0] is unsigned. On each fb_edge it captures the number of system clock ticks since the most recent ref_edge, saturating at 2^FRAC_W-1, and the field holds that value until the next fb_edge. When fb_edge and ref_edge occur in the same cycle, the field captures 0. Each sample reports the fine value as it stands after that cycle's capture.
- R8: clr=1 sets the slip count to 0 in that cycle, and edges in that cycle do not change the count. A sample taken in that cycle reports a count of 0. The fine field is not affected by clr.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Synchronous clear of the slip count |
| mode_multi | input | 1 | 1 = combined multicycle mode, 0 = plain phase/frequency mode |
| low_rate | input | 1 | Reference at or below 8 kHz; forces plain mode |
| ref_edge | input | 1 | One-cycle strobe per reference clock edge |
| fb_edge | input | 1 | One-cycle strobe per feedback clock edge |
| err_out | output | OUT_W (22) | Signed phase error: slip count over fine ticks |
| err_valid | output | 1 | One-cycle strobe: new err_out sample |

## Verification
A wrong slip count cannot be seen on its own. It only shows up in the upper field of the next sample, so a miscount of fb-only edges between reference edges reaches the ports one cycle after the next reference edge. The fine field shows a stale or misaligned capture at that same sample. The bench drives reference and feedback patterns with gaps of one cycle, so each register's effect on the output comes out within two clocks. A reference model compares valid and the full error word on every clock.

// File: rtl/phase_err_mcpd.sv
module phase_err_mcpd #(
  parameter int MAX_SLIP = 8191,
  parameter int FRAC_W = 8,
  localparam int CNT_W = $clog2(MAX_SLIP + 1) + 1,
  localparam int OUT_W = CNT_W + FRAC_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    mode_multi,
  input  logic                    low_rate,
  input  logic                    ref_edge,
  input  logic                    fb_edge,
  output logic signed [OUT_W-1:0] err_out,
  output logic                    err_valid
);

  logic signed [CNT_W-1:0] slip_q, slip_d;
  logic signed [CNT_W:0]   sum, lim, neg_lim;
  logic [FRAC_W-1:0]       age_q, frac_q, frac_d;

  wire plain = !mode_multi || low_rate;
  wire up    = ref_edge && !fb_edge;
  wire dn    = fb_edge && !ref_edge;

  assign lim     = plain ? (CNT_W+1)'(1) : (CNT_W+1)'(MAX_SLIP);
  assign neg_lim = -lim;

  always_comb begin
    sum = {slip_q[CNT_W-1], slip_q} + (CNT_W+1)'(up) - (CNT_W+1)'(dn);
    if (clr)
      slip_d = '0;
    else if (sum > lim)
      slip_d = lim[CNT_W-1:0];
    else if (sum < neg_lim)
      slip_d = neg_lim[CNT_W-1:0];
    else
      slip_d = sum[CNT_W-1:0];
  end

  always_comb begin
    if (fb_edge)
      frac_d = ref_edge ? '0 : age_q;
    else
      frac_d = frac_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slip_q    <= '0;
      age_q     <= '0;
      frac_q    <= '0;
      err_out   <= '0;
      err_valid <= 1'b0;
    end else begin
      slip_q    <= slip_d;
      frac_q    <= frac_d;
      age_q     <= ref_edge ? FRAC_W'(1) : (&age_q ? age_q : age_q + FRAC_W'(1));
      err_valid <= ref_edge;
      if (ref_edge)
        err_out <= {slip_d, frac_d};
    end
  end

endmodule

// File: rtl/phase_err_mcpd_chk.sv
module phase_err_mcpd_chk #(
  parameter int MAX_SLIP = 8191,
  parameter int FRAC_W = 8,
  localparam int CNT_W = $clog2(MAX_SLIP + 1) + 1,
  localparam int OUT_W = CNT_W + FRAC_W
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    clr,
  input logic                    mode_multi,
  input logic                    low_rate,
  input logic                    ref_edge,
  input logic                    fb_edge,
  input logic signed [OUT_W-1:0] err_out,
  input logic                    err_valid
);

  wire signed [CNT_W-1:0] slip_f = err_out[OUT_W-1:FRAC_W];
  wire [FRAC_W-1:0]       frac_f = err_out[FRAC_W-1:0];

  assert_valid_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_valid) |-> $past(ref_edge));

  assert_err_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(err_out) |-> err_valid);

  assert_slip_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> (int'(slip_f) <= MAX_SLIP && int'(slip_f) >= -MAX_SLIP));

  assert_plain_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && $past(!mode_multi || low_rate)) |-> (int'(slip_f) <= 1 && int'(slip_f) >= -1));

  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && $past(clr)) |-> slip_f == '0);

  assert_cancel_frac_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && $past(fb_edge)) |-> frac_f == '0);

endmodule

bind phase_err_mcpd phase_err_mcpd_chk #(.MAX_SLIP(MAX_SLIP), .FRAC_W(FRAC_W)) u_chk (.*);

// File: tb/test_phase_err_mcpd.sv
module test_phase_err_mcpd;
  localparam int CLK_PERIOD = 10;
  localparam int MAXS = 8191;
  localparam int FW = 8;
  localparam int FMAX = (1 << FW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, mode_multi = 1'b1, low_rate = 1'b0, ref_edge = 1'b0, fb_edge = 1'b0;
  logic signed [21:0] err_out;
  logic err_valid;

  int checks = 0, fails = 0;
  int m_cnt = 0, m_age = 0, m_frac = 0, m_err = 0, m_vld = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_err_mcpd i_phase_err_mcpd (
    .clk(clk), .rst_n(rst_n), .clr(clr), .mode_multi(mode_multi), .low_rate(low_rate),
    .ref_edge(ref_edge), .fb_edge(fb_edge), .err_out(err_out), .err_valid(err_valid));

  task automatic compare();
    checks++;
    if (int'(err_valid) != m_vld || int'(err_out) != m_err) begin
      fails++;
      $display("FAIL %s: valid=%0d err=%0d expected valid=%0d err=%0d at %0t",
               cur_req, err_valid, err_out, m_vld, m_err, $time);
    end
  endtask

  task automatic cyc(input logic r, input logic f);
    int lim, s;
    ref_edge = r;
    fb_edge  = f;
    @(posedge clk);
    lim = (!mode_multi || low_rate) ? 1 : MAXS;
    if (f) m_frac = r ? 0 : m_age;
    s = m_cnt + ((r && !f) ? 1 : 0) - ((f && !r) ? 1 : 0);
    if (s > lim) s = lim;
    if (s < -lim) s = -lim;
    m_cnt = clr ? 0 : s;
    m_vld = r ? 1 : 0;
    if (r) m_err = m_cnt * (1 << FW) + m_frac;
    m_age = r ? 1 : ((m_age == FMAX) ? m_age : m_age + 1);
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    compare();
    rst_n = 1'b1;
    cyc(0, 0);
    cyc(0, 0);

    // R2, R3: periodic reference, feedback lagging three ticks
    cur_req = "R2";
    for (int i = 0; i < 6; i++) begin
      cyc(1, 0); cyc(0, 0); cyc(0, 0); cyc(0, 1); cyc(0, 0);
    end
    // R3: reference running faster, feedback-only stretches, simultaneous edges
    cur_req = "R3";
    for (int i = 0; i < 10; i++) begin cyc(1, 0); cyc(0, 0); end
    for (int i = 0; i < 4; i++) begin cyc(0, 1); cyc(0, 1); cyc(1, 1); end
    for (int i = 0; i < 25; i++) begin cyc(0, 1); cyc(0, 0); end
    cyc(1, 0);

    // R4: saturate upwards then downwards
    cur_req = "R4";
    for (int i = 0; i < MAXS + 40; i++) cyc(1, 0);
    for (int i = 0; i < 2 * MAXS + 40; i++) cyc(0, 1);
    cyc(1, 0);
    cyc(1, 1);
    cyc(0, 1);
    cyc(1, 0);

    // R5: plain mode clamps a large count
    cur_req = "R5";
    clr = 1'b1; cyc(0, 0); clr = 1'b0;
    for (int i = 0; i < 30; i++) cyc(1, 0);
    mode_multi = 1'b0;
    cyc(0, 0); cyc(1, 0); cyc(1, 0);
    for (int i = 0; i < 5; i++) begin cyc(0, 1); cyc(1, 0); end
    cyc(0, 1); cyc(0, 1); cyc(0, 1); cyc(1, 1);
    mode_multi = 1'b1;
    for (int i = 0; i < 5; i++) cyc(1, 0);

    // R6: low-rate flag forces plain mode
    cur_req = "R6";
    low_rate = 1'b1;
    cyc(1, 0); cyc(1, 0); cyc(0, 1); cyc(0, 1); cyc(0, 1); cyc(1, 0);
    low_rate = 1'b0;
    for (int i = 0; i < 4; i++) cyc(0, 1);
    cyc(1, 0);

    // R7: fine ticks, including saturation and simultaneous capture
    cur_req = "R7";
    cyc(1, 0);
    for (int i = 0; i < 300; i++) cyc(0, 0);
    cyc(0, 1); cyc(1, 0);
    for (int i = 0; i < 9; i++) cyc(0, 0);
    cyc(0, 1); cyc(0, 0); cyc(1, 0);
    cyc(1, 1); cyc(0, 0); cyc(1, 0);

    // R8: clear with coincident edges, fine field untouched
    cur_req = "R8";
    cyc(0, 0); cyc(0, 0); cyc(0, 1);
    for (int i = 0; i < 5; i++) cyc(1, 0);
    clr = 1'b1; cyc(1, 0); cyc(0, 1); clr = 1'b0;
    cyc(1, 0); cyc(0, 0); cyc(1, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule